// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a memory device. A 16-state controller steps through its state graph on each rising edge of the test clock, steered by the mode-select input. The controller's position decides whether the 3-bit instruction register or one of three data registers sits between the serial input and the serial output. The three data registers are a 1-bit bypass stage, a 32-bit identification register and a boundary register whose length is a parameter.

The instruction in force selects the data register and sets two control outputs for the device's I/O ring. One output hands the pins to the boundary update latches for external test. The other forces the functional outputs to high impedance while the pins are sampled. Every code that no instruction claims acts as a bypass.

Top module: `scan_tap_ctrl`

## Requirements
- R1: The controller follows the standard 16-state test-port graph on the rising clock edge. From any state, five consecutive rising edges with the mode-select input high reach Test-Logic-Reset.
- R2: While rst_ni is low, the block holds Test-Logic-Reset with the identification instruction in force. In that condition tdo_oe_o, tdo_o, bnd_drive_o, outs_hiz_o and bnd_upd_o are all 0.
- R3: tdo_o and tdo_oe_o change only on the falling clock edge. tdo_oe_o is 1 exactly while the controller is in Shift-IR or Shift-DR.
- R4: In Capture-IR the instruction shifter loads 3'b001. Bits shift in and out least significant bit first. The shifter's value becomes the active instruction on the rising edge that leaves Update-IR, and at no other time except reset.
- R5: The instruction codes are 000 external test, 001 identification, 010 sample with outputs forced off, 100 sample/preload and 111 bypass. On the rising edge taken in Test-Logic-Reset, the active instruction returns to 001.
- R6: Under 001, Capture-DR loads the 32-bit ID_VALUE, and it is shifted out least significant bit first. Bit 0 of ID_VALUE is 1.
- R7: Under 111, the data path is a single stage that captures 0, so tdo_o shows the input bit from one shift earlier.
- R8: The unused codes 011, 101 and 110 behave exactly as 111.
- R9: Under 000, 010 and 100, Capture-DR loads pins_i into the boundary register, with bit 0 nearest tdo_o. The register shifts BSR_LEN bits, and its content moves to bnd_upd_o on the rising edge that leaves Update-DR.
- R10: outs_hiz_o is 1 exactly while 010 is in force. bnd_drive_o is 1 exactly while 000 is in force.
- R11: An Update-DR under any instruction that does not select the boundary register leaves bnd_upd_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Mode select, sampled on rising edge |
| tdi_i | input | 1 | Serial data in, sampled on rising edge |
| tdo_o | output | 1 | Serial data out, changes on falling edge |
| tdo_oe_o | output | 1 | Output enable for tdo_o |
| pins_i | input | BSR_LEN | Parallel pin values captured by the boundary register |
| bnd_upd_o | output | BSR_LEN | Boundary update latches |
| bnd_drive_o | output | 1 | External test active: pins follow bnd_upd_o |
| outs_hiz_o | output | 1 | Functional outputs forced to high impedance |

## Verification
The boundary update and the next capture can fall in adjacent edges with no idle state between them. The test leaves Update-DR straight into Select-DR-Scan and then into Capture-DR. It changes pins_i in the one cycle between the two edges, so the load of bnd_upd_o and the capture of the new pin values land back to back. A behavioural model in the bench predicts tdo_o, tdo_oe_o, bnd_upd_o and both control outputs, and it judges them after every falling edge. The bench also checks each shifted-out word against values it computes itself.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [3:0] {
    TLR, RTI,
    SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;
  typedef logic [IR_W-1:0] instr_t;

  localparam instr_t I_EXTEST   = 3'b000;
  localparam instr_t I_IDCODE   = 3'b001;
  localparam instr_t I_SAMPLE_Z = 3'b010;
  localparam instr_t I_SAMPLE   = 3'b100;
  localparam instr_t I_BYPASS   = 3'b111;

  localparam logic [1:0] IR_CAPT = 2'b01;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

  function automatic dr_sel_e dr_select(instr_t i);
    case (i)
      I_EXTEST, I_SAMPLE_Z, I_SAMPLE: return SEL_BSR;
      I_IDCODE:                       return SEL_ID;
      default:                        return SEL_BYP;
    endcase
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TLR:    state_d = tms_i ? TLR    : RTI;
      RTI:    state_d = tms_i ? SEL_DR : RTI;
      SEL_DR: state_d = tms_i ? SEL_IR : CAP_DR;
      CAP_DR: state_d = tms_i ? EX1_DR : SH_DR;
      SH_DR:  state_d = tms_i ? EX1_DR : SH_DR;
      EX1_DR: state_d = tms_i ? UPD_DR : PAU_DR;
      PAU_DR: state_d = tms_i ? EX2_DR : PAU_DR;
      EX2_DR: state_d = tms_i ? UPD_DR : SH_DR;
      UPD_DR: state_d = tms_i ? SEL_DR : RTI;
      SEL_IR: state_d = tms_i ? TLR    : CAP_IR;
      CAP_IR: state_d = tms_i ? EX1_IR : SH_IR;
      SH_IR:  state_d = tms_i ? EX1_IR : SH_IR;
      EX1_IR: state_d = tms_i ? UPD_IR : PAU_IR;
      PAU_IR: state_d = tms_i ? EX2_IR : PAU_IR;
      EX2_IR: state_d = tms_i ? UPD_IR : SH_IR;
      UPD_IR: state_d = tms_i ? SEL_DR : RTI;
      default: state_d = TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // run length of tms high, saturating at 5
  logic [2:0] ones_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)              ones_q <= '0;
    else if (!tms_i)          ones_q <= '0;
    else if (ones_q != 3'd5)  ones_q <= ones_q + 3'd1;
  end

  p_five_ones_tlr_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ones_q == 3'd5) |-> (state_q == TLR));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       tdi_i,
  output instr_t     instr_o,
  output logic       lsb_o
);
  instr_t sr_q, instr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      instr_q <= I_IDCODE;
    end else begin
      case (state_i)
        CAP_IR:  sr_q <= {{(IR_W-2){1'b0}}, IR_CAPT};
        SH_IR:   sr_q <= {tdi_i, sr_q[IR_W-1:1]};
        default: sr_q <= sr_q;
      endcase
      if (state_i == TLR)         instr_q <= I_IDCODE;
      else if (state_i == UPD_IR) instr_q <= sr_q;
    end
  end

  assign instr_o = instr_q;
  assign lsb_o   = sr_q[0];

  p_ir_capture_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == CAP_IR) |=> (sr_q[1:0] == 2'b01));
  p_instr_hold_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(state_i inside {TLR, UPD_IR}) |=> $stable(instr_o));
  p_tlr_default_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TLR) |=> (instr_o == I_IDCODE));
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int          BSR_LEN  = 16,
  parameter logic [31:0] ID_VALUE = 32'h4B1D_2E6F
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  tap_state_e         state_i,
  input  dr_sel_e            sel_i,
  input  logic               tdi_i,
  input  logic [BSR_LEN-1:0] pins_i,
  output logic               lsb_o,
  output logic [BSR_LEN-1:0] bnd_upd_o
);
  localparam int ID_W = 32;

  logic cap, shf, upd;
  assign cap = (state_i == CAP_DR);
  assign shf = (state_i == SH_DR);
  assign upd = (state_i == UPD_DR);

  logic            byp_q;
  logic [ID_W-1:0] id_sr;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= 1'b0;
      id_sr <= '0;
    end else begin
      if (sel_i == SEL_BYP) begin
        if (cap)      byp_q <= 1'b0;
        else if (shf) byp_q <= tdi_i;
      end
      if (sel_i == SEL_ID) begin
        if (cap)      id_sr <= ID_VALUE;
        else if (shf) id_sr <= {tdi_i, id_sr[ID_W-1:1]};
      end
    end
  end

  logic [BSR_LEN-1:0] bsr_sh, bsr_in, bsr_up;
  logic               bsel;
  assign bsel = (sel_i == SEL_BSR);

  for (genvar g = 0; g < BSR_LEN; g++) begin : g_cell
    if (g == BSR_LEN-1) begin : g_head
      assign bsr_in[g] = tdi_i;
    end else begin : g_link
      assign bsr_in[g] = bsr_sh[g+1];
    end

    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bsr_sh[g] <= 1'b0;
        bsr_up[g] <= 1'b0;
      end else if (bsel) begin
        if (cap)      bsr_sh[g] <= pins_i[g];
        else if (shf) bsr_sh[g] <= bsr_in[g];
        if (upd)      bsr_up[g] <= bsr_sh[g];
      end
    end
  end

  always_comb begin
    case (sel_i)
      SEL_BYP: lsb_o = byp_q;
      SEL_ID:  lsb_o = id_sr[0];
      default: lsb_o = bsr_sh[0];
    endcase
  end

  assign bnd_upd_o = bsr_up;

  p_id_capture_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cap && sel_i == SEL_ID) |=> (id_sr == ID_VALUE));
  p_bypass_zero_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cap && sel_i == SEL_BYP) |=> (lsb_o == 1'b0));
  p_bsr_update_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (upd && bsel) |=> (bnd_upd_o == $past(bsr_sh)));
  p_upd_hold_r11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !bsel |=> $stable(bnd_upd_o));
endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import tap_pkg::*;
#(
  parameter int          BSR_LEN  = 16,
  parameter logic [31:0] ID_VALUE = 32'h4B1D_2E6F
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tms_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  output logic               tdo_oe_o,
  input  logic [BSR_LEN-1:0] pins_i,
  output logic [BSR_LEN-1:0] bnd_upd_o,
  output logic               bnd_drive_o,
  output logic               outs_hiz_o
);
  tap_state_e state;
  instr_t     instr;
  dr_sel_e    sel;
  logic       ir_lsb, dr_lsb;

  tap_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  tap_ir u_ir (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .tdi_i   (tdi_i),
    .instr_o (instr),
    .lsb_o   (ir_lsb)
  );

  assign sel = dr_select(instr);

  tap_dr #(
    .BSR_LEN  (BSR_LEN),
    .ID_VALUE (ID_VALUE)
  ) u_dr (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .sel_i     (sel),
    .tdi_i     (tdi_i),
    .pins_i    (pins_i),
    .lsb_o     (dr_lsb),
    .bnd_upd_o (bnd_upd_o)
  );

  logic oe_d, tdo_d;
  assign oe_d  = (state == SH_IR) || (state == SH_DR);
  assign tdo_d = (state == SH_IR) ? ir_lsb : dr_lsb;

  // launch on falling edge for half a cycle of hold at the receiver
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_oe_o <= 1'b0;
      tdo_o    <= 1'b0;
    end else begin
      tdo_oe_o <= oe_d;
      tdo_o    <= oe_d ? tdo_d : 1'b0;
    end
  end

  assign bnd_drive_o = (instr == I_EXTEST);
  assign outs_hiz_o  = (instr == I_SAMPLE_Z);

  p_tdo_oe_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o == (state inside {SH_IR, SH_DR}));
  p_ctrl_excl_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(outs_hiz_o) |-> $past(state) == UPD_IR);
endmodule

// File: tb/scan_tap_ctrl_bench.sv
module scan_tap_ctrl_bench;
  localparam int          N  = 12;
  localparam logic [31:0] ID = 32'h1357_9BDF;

  logic tck = 1'b0, rst_ni = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [N-1:0] pins = '0;
  logic tdo_o, tdo_oe_o, bnd_drive_o, outs_hiz_o;
  logic [N-1:0] bnd_upd_o;

  always #4 tck = ~tck;

  scan_tap_ctrl #(.BSR_LEN(N), .ID_VALUE(ID)) u_scan_tap_ctrl (
    .tck_i(tck), .rst_ni(rst_ni), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo_o), .tdo_oe_o(tdo_oe_o), .pins_i(pins),
    .bnd_upd_o(bnd_upd_o), .bnd_drive_o(bnd_drive_o), .outs_hiz_o(outs_hiz_o)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  localparam int M_TLR=0, M_RTI=1, M_SDR=2, M_CDR=3, M_SHDR=4, M_E1DR=5, M_PDR=6, M_E2DR=7,
                 M_UDR=8, M_SIR=9, M_CIR=10, M_SHIR=11, M_E1IR=12, M_PIR=13, M_E2IR=14, M_UIR=15;

  int           m_st = M_TLR;
  logic [2:0]   m_ins = 3'b001;
  logic [N-1:0] m_upd = '0;
  bit           q_ir[$];
  bit           q_dr[$];

  function automatic int nxt(int s, logic t);
    case (s)
      M_TLR:  return t ? M_TLR  : M_RTI;
      M_RTI:  return t ? M_SDR  : M_RTI;
      M_SDR:  return t ? M_SIR  : M_CDR;
      M_CDR:  return t ? M_E1DR : M_SHDR;
      M_SHDR: return t ? M_E1DR : M_SHDR;
      M_E1DR: return t ? M_UDR  : M_PDR;
      M_PDR:  return t ? M_E2DR : M_PDR;
      M_E2DR: return t ? M_UDR  : M_SHDR;
      M_UDR:  return t ? M_SDR  : M_RTI;
      M_SIR:  return t ? M_TLR  : M_CIR;
      M_CIR:  return t ? M_E1IR : M_SHIR;
      M_SHIR: return t ? M_E1IR : M_SHIR;
      M_E1IR: return t ? M_UIR  : M_PIR;
      M_PIR:  return t ? M_E2IR : M_PIR;
      M_E2IR: return t ? M_UIR  : M_SHIR;
      default: return t ? M_SDR : M_RTI;
    endcase
  endfunction

  function automatic int msel(logic [2:0] c); // 0 bypass, 1 id, 2 boundary
    if (c == 3'b000 || c == 3'b010 || c == 3'b100) return 2;
    if (c == 3'b001) return 1;
    return 0;
  endfunction

  always @(posedge tck) begin
    if (rst_ni) begin
      case (m_st)
        M_CIR:  begin q_ir.delete(); q_ir.push_back(1); q_ir.push_back(0); q_ir.push_back(0); end
        M_SHIR: begin void'(q_ir.pop_front()); q_ir.push_back(tdi); end
        M_UIR:  m_ins = {q_ir[2], q_ir[1], q_ir[0]};
        M_CDR: begin
          q_dr.delete();
          case (msel(m_ins))
            0: q_dr.push_back(0);
            1: for (int i = 0; i < 32; i++) q_dr.push_back(ID[i]);
            default: for (int i = 0; i < N; i++) q_dr.push_back(pins[i]);
          endcase
        end
        M_SHDR: begin void'(q_dr.pop_front()); q_dr.push_back(tdi); end
        M_UDR: if (msel(m_ins) == 2) for (int i = 0; i < N; i++) m_upd[i] = q_dr[i];
        default: ;
      endcase
      if (m_st == M_TLR) m_ins = 3'b001;
      m_st = nxt(m_st, tms);
    end
  end

  always begin
    @(posedge tck);
    #6;
    if (rst_ni) begin
      chk("R3 oe", tdo_oe_o, (m_st == M_SHIR || m_st == M_SHDR));
      if (m_st == M_SHIR) chk("R4 tdo", tdo_o, q_ir[0]);
      if (m_st == M_SHDR) chk("R3 tdo", tdo_o, q_dr[0]);
      chk("R10 hiz", outs_hiz_o, m_ins == 3'b010);
      chk("R10 drive", bnd_drive_o, m_ins == 3'b000);
      chk("R9 upd", bnd_upd_o, m_upd);
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge tck) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL R1 watchdog act=%0d exp<=20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input logic t, input logic d);
    tms = t; tdi = d;
    @(posedge tck); #5;
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo_o;
      step(i == 2, code[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input bit from_sel,
                         input bit to_sel, output logic [63:0] dout);
    dout = '0;
    if (!from_sel) step(1, 0);
    step(0, 0); step(0, 0);
    chk("R3 oe in shift", tdo_oe_o, 1'b1);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo_o;
      tms = (i == n-1); tdi = din[i];
      @(posedge tck); #1;
      if (i < n-1) chk("R3 tdo held until falling edge", tdo_o, dout[i]);
      #4;
    end
    step(1, 0);
    step(to_sel, 0);
  endtask

  logic [2:0]  cap;
  logic [63:0] dout;
  logic [N-1:0] upd_prev;

  initial begin
    repeat (3) @(posedge tck);
    #5;
    chk("R2 oe", tdo_oe_o, 0);
    chk("R2 tdo", tdo_o, 0);
    chk("R2 drive", bnd_drive_o, 0);
    chk("R2 hiz", outs_hiz_o, 0);
    chk("R2 upd", bnd_upd_o, 0);
    rst_ni = 1'b1;
    step(0, 0);

    // R5 R6: default instruction reads identification
    scan_dr(32, 64'h0, 0, 0, dout);
    chk("R6 id value", dout[31:0], ID);
    chk("R5 default instr id lsb", dout[0], 1'b1);

    // R4 capture pattern, R9 sample/preload
    load_ir(3'b100, cap);
    chk("R4 ir capture", cap, 3'b001);
    pins = 12'hA5C;
    scan_dr(N, 64'h3B7, 0, 0, dout);
    chk("R9 sample capture", dout[N-1:0], 12'hA5C);
    chk("R9 update", bnd_upd_o, 12'h3B7);
    chk("R10 sample no hiz", outs_hiz_o, 0);

    // R10 sample-z and extest
    load_ir(3'b010, cap);
    chk("R10 samplez hiz", outs_hiz_o, 1);
    chk("R10 samplez no drive", bnd_drive_o, 0);
    pins = 12'h5E1;
    scan_dr(N, 64'hC42, 0, 0, dout);
    chk("R9 samplez capture", dout[N-1:0], 12'h5E1);
    load_ir(3'b000, cap);
    chk("R10 extest drive", bnd_drive_o, 1);
    chk("R10 extest no hiz", outs_hiz_o, 0);
    scan_dr(N, 64'h0F0, 0, 0, dout);
    chk("R9 extest update", bnd_upd_o, 12'h0F0);

    // R7 bypass, R11 no update
    load_ir(3'b111, cap);
    upd_prev = bnd_upd_o;
    scan_dr(5, 64'h16, 0, 0, dout);
    chk("R7 bypass delay", dout[4:0], {4'h6, 1'b0});
    chk("R11 upd held", bnd_upd_o, upd_prev);

    // R8 reserved codes
    for (int k = 0; k < 3; k++) begin
      logic [2:0] rc;
      rc = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
      load_ir(rc, cap);
      scan_dr(4, 64'h9, 0, 0, dout);
      chk("R8 reserved as bypass", dout[3:0], 4'h2);
      chk("R8 reserved ctrl off", {bnd_drive_o, outs_hiz_o}, 2'b00);
      chk("R11 reserved upd held", bnd_upd_o, upd_prev);
    end

    // R1: escape from Shift-DR
    load_ir(3'b111, cap);
    step(1, 0); step(0, 0); step(0, 1); step(0, 0);
    repeat (5) step(1, 0);
    chk("R1 tlr from shift-dr oe", tdo_oe_o, 0);
    step(0, 0);
    scan_dr(32, 64'h0, 0, 0, dout);
    chk("R1 tlr restores id", dout[31:0], ID);

    // R1: escape from Pause-IR with a non-default code shifted in
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(0, 0); step(1, 1); step(0, 0);
    repeat (5) step(1, 0);
    step(0, 0);
    chk("R1 tlr from pause-ir ctrl", {bnd_drive_o, outs_hiz_o}, 2'b00);
    scan_dr(32, 64'h0, 0, 0, dout);
    chk("R5 id after tlr", dout[31:0], ID);

    // R9 back-to-back: update then immediate capture of new pins
    load_ir(3'b100, cap);
    pins = 12'h123;
    scan_dr(N, 64'hABC, 0, 1, dout);
    chk("R9 b2b first capture", dout[N-1:0], 12'h123);
    chk("R9 b2b first update", bnd_upd_o, 12'hABC);
    pins = 12'hFED;
    scan_dr(N, 64'h456, 1, 0, dout);
    chk("R9 b2b second capture", dout[N-1:0], 12'hFED);
    chk("R9 b2b second update", bnd_upd_o, 12'h456);

    repeat (3) step(0, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule